// File: doc/BRIEF.md
# Configurable Macrocell Storage Cell

This block is one output cell of a programmable-logic fabric. A single storage element sits between the cell's data input and its output, and static configuration inputs shape how it behaves. The data can come from the product-term sum or straight from an input pin. The element can act as a D flip-flop, a T flip-flop or a transparent latch. It can also be bypassed, so the cell becomes a plain combinational path.

The clock is chosen from a set of global clocks or from a locally formed product-term clock. The chosen clock can be inverted. In either flip-flop mode the element can capture on both edges. A local product-term clock enable gates capture. The power-up value is configured per cell. Local asynchronous set and reset inputs act on the cell directly. A global set/reset line acts on it only when the cell is configured to respond, and the configuration also says whether that line sets or clears it. A second selector chooses the cell's output enable from several global enables or a local product-term enable.

All configuration inputs are static. They are meant to change only while `rst_n` holds the cell in its initial state.

Top module: `mcell_top`

## Requirements
- R1: With `cfg_mode` = 3 (combinational), `cell_q` equals the selected data input at all times, with no clock needed.
- R2: `cfg_din_pin` = 0 selects `pt_sum` as the data input; `cfg_din_pin` = 1 selects `pin_in`.
- R3: With `cfg_mode` = 0 (D flip-flop), `cell_q` takes the data input at each active edge of the selected clock and holds between edges. `cfg_clk_sel` values 0..NUM_GCLK-1 pick `gclk[i]`; NUM_GCLK and above pick `pt_clk`. `cfg_clk_inv` = 1 makes the falling edge of the source the active edge.
- R4: With `cfg_mode` = 1 (T flip-flop), `cell_q` inverts at an active edge when the data input is 1 and holds when it is 0.
- R5: With `cfg_dual_edge` = 1 in either flip-flop mode, both edges of the selected clock are active. In latch mode the setting has no effect.
- R6: With `cfg_mode` = 2 (latch), `cell_q` follows the data input while the phase-adjusted clock is high and holds while it is low.
- R7: When `pt_ce` is 0, active clock edges leave `cell_q` unchanged, and the open latch does not follow the data input.
- R8: While `rst_n` is low, `cell_q` equals `cfg_init` in every storage mode, regardless of the clock.
- R9: `pt_set` = 1 forces `cell_q` to 1 and `pt_rst` = 1 forces it to 0, at once and over any clock activity. When both are 1, the result is 0. After release, the forced value is held until the next capture.
- R10: With `cfg_gsr_en` = 1, `gsr` = 1 forces `cell_q` to 1 if `cfg_gsr_set` = 1 and to 0 if `cfg_gsr_set` = 0. With `cfg_gsr_en` = 0, `gsr` has no effect.
- R11: `cell_oe` equals `goe[i]` when `cfg_oe_sel` = i < NUM_GOE, and equals `pt_oe` when `cfg_oe_sel` is NUM_GOE or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Device initialise, active low; loads the configured power-up value |
| gclk | input | NUM_GCLK | Global clocks |
| pt_clk | input | 1 | Local product-term clock |
| pt_sum | input | 1 | Product-term sum data |
| pin_in | input | 1 | Direct pin data |
| pt_ce | input | 1 | Product-term clock enable |
| pt_set | input | 1 | Product-term asynchronous set |
| pt_rst | input | 1 | Product-term asynchronous reset |
| gsr | input | 1 | Global asynchronous set/reset line |
| goe | input | NUM_GOE | Global output enables |
| pt_oe | input | 1 | Product-term output enable |
| cfg_mode | input | 2 | 0 D flop, 1 T flop, 2 latch, 3 combinational |
| cfg_din_pin | input | 1 | Data source: 0 sum, 1 pin |
| cfg_clk_sel | input | CLK_SEL_W | Clock source select |
| cfg_clk_inv | input | 1 | Invert selected clock |
| cfg_dual_edge | input | 1 | Capture on both edges |
| cfg_init | input | 1 | Power-up value |
| cfg_gsr_en | input | 1 | Respond to the global set/reset line |
| cfg_gsr_set | input | 1 | Global line sets (1) or clears (0) |
| cfg_oe_sel | input | OE_SEL_W | Output enable select |
| cell_q | output | 1 | Cell value |
| cell_oe | output | 1 | Selected output enable |

## Verification
The hardest case to reach from the ports is dual-edge capture followed by an asynchronous force. Here the cell value is split across two storage bits clocked on opposite edges, so a force has to leave both bits consistent. The stimulus toggles the cell through rising and falling captures, and then applies set, reset, both together, and a release with set still held. It checks that the value is forced at once and then held until the next capture. Falling-edge capture through clock inversion is reached by stopping partway through a source pulse and sampling after the rising half and again after the falling half.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

    typedef enum logic [1:0] {
        MODE_DFF   = 2'd0,
        MODE_TFF   = 2'd1,
        MODE_LATCH = 2'd2,
        MODE_COMB  = 2'd3
    } cell_mode_e;

    // state of the two opposite-edge storage bits
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

endpackage

// File: rtl/mcell_clk_mux.sv
module mcell_clk_mux #(
    parameter int NUM_GCLK  = 3,
    parameter int CLK_SEL_W = $clog2(NUM_GCLK + 1)
) (
    input  logic [NUM_GCLK-1:0]  gclk,
    input  logic                 pt_clk,
    input  logic [CLK_SEL_W-1:0] sel,
    input  logic                 inv,
    output logic                 ck
);

    logic src;

    always_comb begin
        src = pt_clk;
        for (int i = 0; i < NUM_GCLK; i++) begin
            if (sel == CLK_SEL_W'(i)) src = gclk[i];
        end
        ck = src ^ inv;
    end

endmodule

// File: rtl/mcell_async_ctl.sv
module mcell_async_ctl (
    input  logic rst_n,
    input  logic cfg_init,
    input  logic gsr,
    input  logic cfg_gsr_en,
    input  logic cfg_gsr_set,
    input  logic pt_set,
    input  logic pt_rst,
    output logic a_clr,
    output logic a_set
);

    logic want_clr;
    logic want_set;

    always_comb begin
        if (!rst_n) begin
            want_clr = !cfg_init;
            want_set = cfg_init;
        end else begin
            want_clr = pt_rst | (gsr & cfg_gsr_en & !cfg_gsr_set);
            want_set = pt_set | (gsr & cfg_gsr_en & cfg_gsr_set);
        end
        // clear dominates; set re-asserts as an edge when clear drops
        a_clr = want_clr;
        a_set = want_set & !want_clr;
    end

endmodule

// File: rtl/mcell_oe_mux.sv
module mcell_oe_mux #(
    parameter int NUM_GOE  = 4,
    parameter int OE_SEL_W = $clog2(NUM_GOE + 1)
) (
    input  logic [NUM_GOE-1:0]  goe,
    input  logic                pt_oe,
    input  logic [OE_SEL_W-1:0] sel,
    output logic                oe
);

    always_comb begin
        oe = pt_oe;
        for (int i = 0; i < NUM_GOE; i++) begin
            if (sel == OE_SEL_W'(i)) oe = goe[i];
        end
    end

endmodule

// File: rtl/mcell_store.sv
module mcell_store
    import mcell_pkg::*;
(
    input  logic       ck,
    input  logic       a_clr,
    input  logic       a_set,
    input  logic       d,
    input  logic       ce,
    input  cell_mode_e mode,
    input  logic       dual,
    output logic       q
);

    edge_pair_t pair_d;
    edge_pair_t pair_q;
    logic       lat_q;
    logic       cur;
    logic       nv;
    logic       a_any;

    assign a_any = a_clr | a_set;
    assign cur   = pair_q.rise ^ pair_q.fall;

    // next value of the flip-flop as a whole, then encoded into the pair
    always_comb begin
        if (!ce)                  nv = cur;
        else if (mode == MODE_TFF) nv = cur ^ d;
        else                      nv = d;
        pair_d.rise = nv ^ pair_q.fall;
        pair_d.fall = dual ? (nv ^ pair_q.rise) : pair_q.fall;
    end

    always_ff @(posedge ck or posedge a_clr or posedge a_set) begin
        if (a_clr)      pair_q.rise <= 1'b0;
        else if (a_set) pair_q.rise <= 1'b1;
        else            pair_q.rise <= pair_d.rise;
    end

    always_ff @(negedge ck or posedge a_any) begin
        if (a_any) pair_q.fall <= 1'b0;
        else       pair_q.fall <= pair_d.fall;
    end

    always_latch begin
        if (a_clr)           lat_q = 1'b0;
        else if (a_set)      lat_q = 1'b1;
        else if (ck && ce)   lat_q = d;
    end

    always_comb begin
        case (mode)
            MODE_COMB:  q = d;
            MODE_LATCH: q = lat_q;
            default:    q = cur;
        endcase
    end

endmodule

// File: rtl/mcell_top.sv
module mcell_top
    import mcell_pkg::*;
#(
    parameter int NUM_GCLK  = 3,
    parameter int NUM_GOE   = 4,
    localparam int CLK_SEL_W = $clog2(NUM_GCLK + 1),
    localparam int OE_SEL_W  = $clog2(NUM_GOE + 1)
) (
    input  logic                 rst_n,
    input  logic [NUM_GCLK-1:0]  gclk,
    input  logic                 pt_clk,
    input  logic                 pt_sum,
    input  logic                 pin_in,
    input  logic                 pt_ce,
    input  logic                 pt_set,
    input  logic                 pt_rst,
    input  logic                 gsr,
    input  logic [NUM_GOE-1:0]   goe,
    input  logic                 pt_oe,
    input  logic [1:0]           cfg_mode,
    input  logic                 cfg_din_pin,
    input  logic [CLK_SEL_W-1:0] cfg_clk_sel,
    input  logic                 cfg_clk_inv,
    input  logic                 cfg_dual_edge,
    input  logic                 cfg_init,
    input  logic                 cfg_gsr_en,
    input  logic                 cfg_gsr_set,
    input  logic [OE_SEL_W-1:0]  cfg_oe_sel,
    output logic                 cell_q,
    output logic                 cell_oe
);

    cell_mode_e mode;
    logic       d_sel;
    logic       ck_sel;
    logic       a_clr;
    logic       a_set;

    assign mode  = cell_mode_e'(cfg_mode);
    assign d_sel = cfg_din_pin ? pin_in : pt_sum;

    mcell_clk_mux #(.NUM_GCLK(NUM_GCLK), .CLK_SEL_W(CLK_SEL_W)) u_ck (
        .gclk(gclk), .pt_clk(pt_clk), .sel(cfg_clk_sel), .inv(cfg_clk_inv), .ck(ck_sel)
    );

    mcell_async_ctl u_as (
        .rst_n(rst_n), .cfg_init(cfg_init), .gsr(gsr), .cfg_gsr_en(cfg_gsr_en),
        .cfg_gsr_set(cfg_gsr_set), .pt_set(pt_set), .pt_rst(pt_rst),
        .a_clr(a_clr), .a_set(a_set)
    );

    mcell_store u_st (
        .ck(ck_sel), .a_clr(a_clr), .a_set(a_set), .d(d_sel), .ce(pt_ce),
        .mode(mode), .dual(cfg_dual_edge), .q(cell_q)
    );

    mcell_oe_mux #(.NUM_GOE(NUM_GOE), .OE_SEL_W(OE_SEL_W)) u_oe (
        .goe(goe), .pt_oe(pt_oe), .sel(cfg_oe_sel), .oe(cell_oe)
    );

    // R1: bypass mode presents the data input directly
    a_r1_comb_follows: assert property (@(posedge gclk[0]) disable iff (!rst_n)
        (mode == MODE_COMB) |-> (cell_q == d_sel));

    // R6: an open, enabled latch is transparent
    a_r6_latch_open: assert property (@(posedge gclk[0]) disable iff (!rst_n)
        (mode == MODE_LATCH && ck_sel && pt_ce && !a_clr && !a_set) |-> (cell_q == d_sel));

    // R9: a pending clear holds the stored value at 0
    a_r9_clear_forces: assert property (@(posedge gclk[0]) disable iff (!rst_n)
        (a_clr && mode != MODE_COMB) |-> (cell_q == 1'b0));

    // R9: a pending set, with no clear, holds the stored value at 1
    a_r9_set_forces: assert property (@(posedge gclk[0]) disable iff (!rst_n)
        (a_set && mode != MODE_COMB) |-> (cell_q == 1'b1));

endmodule

// File: tb/sim_mcell_top.sv
module sim_mcell_top;

    localparam int NG = 3;
    localparam int NO = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic          rst_n = 1'b0;
    logic [NG-1:0] gclk = '0;
    logic          pt_clk = 1'b0, pt_sum = 1'b0, pin_in = 1'b0, pt_ce = 1'b1;
    logic          pt_set = 1'b0, pt_rst = 1'b0, gsr = 1'b0, pt_oe = 1'b0;
    logic [NO-1:0] goe = '0;
    logic [1:0]    cfg_mode = 2'd0;
    logic          cfg_din_pin = 1'b0, cfg_clk_inv = 1'b0, cfg_dual_edge = 1'b0;
    logic          cfg_init = 1'b0, cfg_gsr_en = 1'b0, cfg_gsr_set = 1'b0;
    logic [1:0]    cfg_clk_sel = 2'd0;
    logic [2:0]    cfg_oe_sel = 3'd0;
    logic          cell_q, cell_oe;

    mcell_top #(.NUM_GCLK(NG), .NUM_GOE(NO)) u0 (
        .rst_n(rst_n), .gclk(gclk), .pt_clk(pt_clk), .pt_sum(pt_sum), .pin_in(pin_in),
        .pt_ce(pt_ce), .pt_set(pt_set), .pt_rst(pt_rst), .gsr(gsr), .goe(goe),
        .pt_oe(pt_oe), .cfg_mode(cfg_mode), .cfg_din_pin(cfg_din_pin),
        .cfg_clk_sel(cfg_clk_sel), .cfg_clk_inv(cfg_clk_inv),
        .cfg_dual_edge(cfg_dual_edge), .cfg_init(cfg_init), .cfg_gsr_en(cfg_gsr_en),
        .cfg_gsr_set(cfg_gsr_set), .cfg_oe_sel(cfg_oe_sel),
        .cell_q(cell_q), .cell_oe(cell_oe)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 50000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    // static configuration changes only while held in initialise
    task automatic setup(input logic [1:0] m, input logic [1:0] sel, input logic inv,
                         input logic dual, input logic init);
        rst_n = 1'b0;
        cfg_mode = m; cfg_clk_sel = sel; cfg_clk_inv = inv;
        cfg_dual_edge = dual; cfg_init = init;
        #3;
        rst_n = 1'b1;
        #3;
    endtask

    task automatic src_set(input int s, input logic v);
        if (s < NG) gclk[s] = v;
        else        pt_clk = v;
    endtask

    task automatic pulse(input int s);
        src_set(s, 1'b1); #5;
        src_set(s, 1'b0); #5;
    endtask

    // [6:5] mode, [4] pin select, [3] sum, [2] pin, [1] ce, [0] expected
    localparam logic [6:0] VEC [12] = '{
        7'b0001011, 7'b0000010, 7'b0010111, 7'b0010001,
        7'b0010010, 7'b0101011, 7'b0101010, 7'b0100010,
        7'b0101000, 7'b0101011, 7'b0110110, 7'b0001011
    };

    initial begin
        logic prev;
        string tag;

        // R8: initialise value
        setup(2'd0, 2'd0, 1'b0, 1'b0, 1'b1);
        chk("R8 init one", cell_q, 1'b1);
        rst_n = 1'b0; cfg_init = 1'b0; #2;
        pt_sum = 1'b1; pulse(0);
        chk("R8 init zero held over clock", cell_q, 1'b0);
        pt_sum = 1'b0; rst_n = 1'b1; #3;

        // R3 / R4 / R7 / R2: vector walk on gclk[0] rising
        prev = 1'b0;
        for (int i = 0; i < 12; i++) begin
            cfg_mode = VEC[i][6:5]; cfg_din_pin = VEC[i][4];
            pt_sum = VEC[i][3]; pin_in = VEC[i][2]; pt_ce = VEC[i][1];
            #2;
            chk("R3 hold between edges", cell_q, prev);
            pulse(0);
            if (!VEC[i][1])        tag = "R7 enable low";
            else if (VEC[i][4])    tag = "R2 pin source";
            else if (VEC[i][5])    tag = "R4 toggle";
            else                   tag = "R3 capture";
            chk(tag, cell_q, VEC[i][0]);
            prev = VEC[i][0];
        end
        pt_ce = 1'b1; cfg_din_pin = 1'b0; pt_sum = 1'b0; pin_in = 1'b0;

        // R1 / R2: combinational bypass
        setup(2'd3, 2'd0, 1'b0, 1'b0, 1'b1);
        pt_sum = 1'b0; #1; chk("R1 comb zero", cell_q, 1'b0);
        pt_sum = 1'b1; #1; chk("R1 comb one", cell_q, 1'b1);
        cfg_din_pin = 1'b1; pin_in = 1'b0; #1; chk("R2 comb pin", cell_q, 1'b0);
        cfg_din_pin = 1'b0; pt_sum = 1'b0;

        // R3: source selection
        setup(2'd0, 2'd2, 1'b0, 1'b0, 1'b0);
        pt_sum = 1'b1; pulse(0);
        chk("R3 unselected clock ignored", cell_q, 1'b0);
        pulse(2);
        chk("R3 gclk2 selected", cell_q, 1'b1);
        setup(2'd0, 2'd3, 1'b0, 1'b0, 1'b0);
        pt_sum = 1'b1; pulse(1);
        chk("R3 gclk1 ignored under local", cell_q, 1'b0);
        pulse(3);
        chk("R3 local clock selected", cell_q, 1'b1);

        // R3: inverted phase captures on the source falling edge
        setup(2'd0, 2'd1, 1'b1, 1'b0, 1'b0);
        pt_sum = 1'b1; #2;
        src_set(1, 1'b1); #3;
        chk("R3 inverted no capture on rise", cell_q, 1'b0);
        src_set(1, 1'b0); #3;
        chk("R3 inverted capture on fall", cell_q, 1'b1);

        // R5: dual edge, D mode
        setup(2'd0, 2'd0, 1'b0, 1'b1, 1'b0);
        pt_sum = 1'b1; #2; src_set(0, 1'b1); #3;
        chk("R5 dual rise", cell_q, 1'b1);
        pt_sum = 1'b0; #2; src_set(0, 1'b0); #3;
        chk("R5 dual fall", cell_q, 1'b0);
        pt_sum = 1'b1; #2; src_set(0, 1'b1); #3;
        chk("R5 dual rise again", cell_q, 1'b1);
        src_set(0, 1'b0); #3;
        chk("R5 dual fall same data", cell_q, 1'b1);

        // R5: dual edge, T mode
        setup(2'd1, 2'd0, 1'b0, 1'b1, 1'b0);
        pt_sum = 1'b1; #2; src_set(0, 1'b1); #3;
        chk("R5 dual toggle rise", cell_q, 1'b1);
        src_set(0, 1'b0); #3;
        chk("R5 dual toggle fall", cell_q, 1'b0);
        src_set(0, 1'b1); #3;
        chk("R5 dual toggle rise 2", cell_q, 1'b1);

        // R9: force on a split dual-edge state, then release
        pt_rst = 1'b1; #2;
        chk("R9 reset forces", cell_q, 1'b0);
        pt_set = 1'b1; #2;
        chk("R9 reset wins over set", cell_q, 1'b0);
        pt_rst = 1'b0; #2;
        chk("R9 set takes over on reset release", cell_q, 1'b1);
        pt_sum = 1'b0; src_set(0, 1'b0); #3; src_set(0, 1'b1); #3;
        chk("R9 set overrides clock", cell_q, 1'b1);
        pt_set = 1'b0; #2;
        chk("R9 held after release", cell_q, 1'b1);
        src_set(0, 1'b0); #3;
        chk("R9 hold under zero toggle", cell_q, 1'b1);
        pt_sum = 1'b1; src_set(0, 1'b1); #3;
        chk("R9 capture resumes", cell_q, 1'b0);
        src_set(0, 1'b0); pt_sum = 1'b0; #3;

        // R6 / R7 / R5: latch
        setup(2'd2, 2'd0, 1'b0, 1'b1, 1'b0);
        pt_sum = 1'b1; #2;
        chk("R6 latch closed holds", cell_q, 1'b0);
        src_set(0, 1'b1); #2;
        chk("R6 latch open follows", cell_q, 1'b1);
        pt_sum = 1'b0; #2;
        chk("R6 latch open tracks", cell_q, 1'b0);
        pt_ce = 1'b0; pt_sum = 1'b1; #2;
        chk("R7 latch enable low", cell_q, 1'b0);
        pt_ce = 1'b1; #2;
        chk("R6 latch reopen", cell_q, 1'b1);
        src_set(0, 1'b0); #2;
        pt_sum = 1'b0; #2;
        chk("R5 no capture on fall in latch", cell_q, 1'b1);

        // R10: global set/reset
        setup(2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
        cfg_gsr_en = 1'b0; cfg_gsr_set = 1'b1;
        gsr = 1'b1; #2;
        chk("R10 ignored when not enabled", cell_q, 1'b0);
        gsr = 1'b0; #2;
        cfg_gsr_en = 1'b1;
        gsr = 1'b1; #2;
        chk("R10 global set", cell_q, 1'b1);
        gsr = 1'b0; #2;
        chk("R10 held after global set", cell_q, 1'b1);
        cfg_gsr_set = 1'b0;
        gsr = 1'b1; #2;
        chk("R10 global reset", cell_q, 1'b0);
        gsr = 1'b0; cfg_gsr_en = 1'b0; #2;

        // R11: output-enable selection
        for (int i = 0; i <= NO; i++) begin
            cfg_oe_sel = 3'(i);
            if (i < NO) begin
                goe = NO'(1 << i); pt_oe = 1'b0; #1;
                chk("R11 global enable high", cell_oe, 1'b1);
                goe = ~NO'(1 << i); pt_oe = 1'b1; #1;
                chk("R11 global enable low", cell_oe, 1'b0);
            end else begin
                goe = '1; pt_oe = 1'b0; #1;
                chk("R11 local enable low", cell_oe, 1'b0);
                goe = '0; pt_oe = 1'b1; #1;
                chk("R11 local enable high", cell_oe, 1'b1);
            end
        end

        summary();
        $finish;
    end

endmodule